// File: doc/BRIEF.md
# Regulator Power-Good and Overvoltage Latch Controller

This block decides the level of the regulator's power-good indicator and keeps the overvoltage-shutdown latch. It takes four inputs: a soft-start-complete strobe, the raw disable sources, an undervoltage comparator flag and an overvoltage comparator flag. The disable sources are power-on reset, the analog enable pin, the logic enable, and the all-ones VID code that reports no CPU is present. From these it drives a power-good level and the matching pull-down enable for an open-drain pad.

Power-good goes high only after soft-start completes, and only while no disable source is active. It falls when any disable source is active or when undervoltage has been seen on two consecutive clock samples. After an undervoltage event it comes back high by itself, unless the controller was disabled in the meantime. Overvoltage never pulls power-good low. Overvoltage sets a sticky shutdown latch. Only power-on reset or a low enable pin clears that latch. The no-CPU code and the logic enable cannot clear it.

Top module: `pgood_ctrl`

## Requirements
- R1: While rst_ni is low, pgood_o is 0, pg_pd_o is 1 and ov_shdn_o is 0.
- R2: When ss_done_i is sampled high at a clock edge and no disable source is active, pgood_o is 1 after that edge.
- R3: pgood_o stays 0 while ss_done_i has not been sampled high since the last disable or reset.
- R4: Any one disable source forces pgood_o to 0 after the edge that samples it. The sources are por_i=1, en_pin_i=0, en_logic_i=0, and vid_i equal to all ones (6'b111111 at the default width). Once the source is removed, pgood_o stays 0 until ss_done_i is sampled high again.
- R5: pgood_o falls after the second of two consecutive edges that sample uv_i=1. A uv_i pulse lasting one cycle leaves pgood_o at 1.
- R6: After an undervoltage drop, pgood_o returns to 1 after the first edge that samples uv_i=0, unless a disable source occurred meanwhile, in which case it stays 0.
- R7: ov_i has no effect on pgood_o.
- R8: ov_shdn_o becomes 1 after an edge that samples ov_i=1, and it stays 1 after ov_i returns to 0.
- R9: ov_shdn_o is cleared only by an edge that samples por_i=1 or en_pin_i=0. The no-CPU VID code and en_logic_i=0 leave it set.
- R10: pg_pd_o is the inverse of pgood_o at all times: the pull-down is active exactly when power-good is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ss_done_i | input | 1 | Soft-start completed |
| por_i | input | 1 | Power-on reset active |
| en_pin_i | input | 1 | Analog enable comparator output |
| en_logic_i | input | 1 | Logic-level enable |
| vid_i | input | VID_W | Voltage ID code; all ones means no CPU |
| uv_i | input | 1 | Undervoltage comparator flag |
| ov_i | input | 1 | Overvoltage comparator flag |
| pgood_o | output | 1 | Power-good level |
| pg_pd_o | output | 1 | Open-drain pull-down enable |
| ov_shdn_o | output | 1 | Latched overvoltage shutdown |

## Verification
The bench applies each of the four disable sources one at a time after a good soft-start. Each run shows that the source drops power-good and also clears the soft-start arming, so that removing the source alone does not bring power-good back. Undervoltage is tried in three forms:
- a one-cycle glitch, which tells the two-sample filter apart from a plain sampler;
- a sustained fault followed by release, which confirms self-recovery;
- a sustained fault with a disable pulse in the middle, which confirms that recovery is blocked.

Overvoltage is held with power-good up to show the two are independent. Each possible clear source is then applied to the latch, which tells the sources that must clear it from those that must not.

// File: rtl/pg_pkg.sv
package pg_pkg;
  typedef struct packed {
    logic por;
    logic pin_lo;
    logic logic_lo;
    logic no_cpu;
  } dis_src_t;
endpackage

// File: rtl/pg_dis_decode.sv
module pg_dis_decode
  import pg_pkg::*;
#(
  parameter int VID_W = 6
) (
  input  logic             por_i,
  input  logic             en_pin_i,
  input  logic             en_logic_i,
  input  logic [VID_W-1:0] vid_i,
  output dis_src_t         src_o,
  output logic             dis_o
);
  localparam logic [VID_W-1:0] NO_CPU = '1;

  always_comb begin
    src_o.por      = por_i;
    src_o.pin_lo   = ~en_pin_i;
    src_o.logic_lo = ~en_logic_i;
    src_o.no_cpu   = (vid_i == NO_CPU);
    dis_o          = |src_o;
  end
endmodule

// File: rtl/pg_uv_filter.sv
module pg_uv_filter #(
  parameter int UV_FILT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic uv_i,
  output logic trip_d_o
);
  localparam int CNT_W = $clog2(UV_FILT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(UV_FILT);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!uv_i)                cnt_d = '0;
    else if (cnt_q == CNT_MAX) cnt_d = cnt_q;
    else                      cnt_d = cnt_q + 1'b1;
    trip_d_o = (cnt_d == CNT_MAX);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R5: count never exceeds the filter length
  a_r5_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);
  // R5: a low sample restarts the count
  a_r5_cnt_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !uv_i |=> cnt_q == '0);
endmodule

// File: rtl/pg_ov_latch.sv
module pg_ov_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ov_i,
  input  logic clr_i,
  output logic ov_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ov_q_o <= 1'b0;
    else if (clr_i) ov_q_o <= 1'b0;
    else if (ov_i)  ov_q_o <= 1'b1;
  end

  a_r8_ov_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ov_i && !clr_i |=> ov_q_o);
  a_r9_ov_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ov_q_o && !clr_i |=> ov_q_o);
  a_r9_ov_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !ov_q_o);
endmodule

// File: rtl/pgood_ctrl.sv
module pgood_ctrl
  import pg_pkg::*;
#(
  parameter int VID_W   = 6,
  parameter int UV_FILT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ss_done_i,
  input  logic             por_i,
  input  logic             en_pin_i,
  input  logic             en_logic_i,
  input  logic [VID_W-1:0] vid_i,
  input  logic             uv_i,
  input  logic             ov_i,
  output logic             pgood_o,
  output logic             pg_pd_o,
  output logic             ov_shdn_o
);
  dis_src_t src;
  logic     dis;
  logic     uv_trip_d;
  logic     armed_q, armed_d;
  logic     pg_q;

  pg_dis_decode #(.VID_W(VID_W)) u_dis (
    .por_i     (por_i),
    .en_pin_i  (en_pin_i),
    .en_logic_i(en_logic_i),
    .vid_i     (vid_i),
    .src_o     (src),
    .dis_o     (dis)
  );

  pg_uv_filter #(.UV_FILT(UV_FILT)) u_uv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .uv_i    (uv_i),
    .trip_d_o(uv_trip_d)
  );

  // latch clear: power-on reset or enable pin low only
  pg_ov_latch u_ov (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ov_i  (ov_i),
    .clr_i (src.por | src.pin_lo),
    .ov_q_o(ov_shdn_o)
  );

  always_comb begin
    if (dis)            armed_d = 1'b0;
    else if (ss_done_i) armed_d = 1'b1;
    else                armed_d = armed_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      pg_q    <= 1'b0;
    end else begin
      armed_q <= armed_d;
      pg_q    <= armed_d & ~uv_trip_d;
    end
  end

  assign pgood_o = pg_q;
  assign pg_pd_o = ~pg_q;

  a_r4_dis_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis |=> !pgood_o);
  a_r2_rise_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pgood_o) |-> !$past(dis));
  a_r3_rise_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pgood_o) |-> $past(ss_done_i) || $past(armed_q));
  a_r5_fall_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pgood_o) && !$past(dis) |-> $past(uv_i) && $past(uv_i, 2));
  a_r10_pd_inverse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pg_pd_o != pgood_o);
endmodule

// File: tb/pgood_ctrl_tb_top.sv
module pgood_ctrl_tb_top;
  localparam int VID_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ss_done = 1'b0, por = 1'b0, en_pin = 1'b1, en_logic = 1'b1;
  logic [VID_W-1:0] vid = 6'd20;
  logic uv = 1'b0, ov = 1'b0;
  logic pgood, pg_pd, ov_shdn;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  pgood_ctrl #(.VID_W(VID_W), .UV_FILT(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ss_done_i(ss_done), .por_i(por),
    .en_pin_i(en_pin), .en_logic_i(en_logic), .vid_i(vid),
    .uv_i(uv), .ov_i(ov), .pgood_o(pgood), .pg_pd_o(pg_pd),
    .ov_shdn_o(ov_shdn)
  );

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic bring_up();
    por = 0; en_pin = 1; en_logic = 1; vid = 6'd20; uv = 0; ov = 0;
    ss_done = 1; step(); ss_done = 0;
  endtask

  task automatic t_reset();
    chk("R1 pgood in reset", pgood, 1'b0);
    chk("R1 pd in reset", pg_pd, 1'b1);
    chk("R1 ov latch in reset", ov_shdn, 1'b0);
    rst_n = 1; step(3);
    chk("R3 no soft-start yet", pgood, 1'b0);
    chk("R10 pd while low", pg_pd, 1'b1);
  endtask

  task automatic t_softstart();
    bring_up();
    chk("R2 rise on ss_done", pgood, 1'b1);
    chk("R10 pd released", pg_pd, 1'b0);
    step(3);
    chk("R2 stays high", pgood, 1'b1);
  endtask

  task automatic t_disables();
    for (int s = 0; s < 4; s++) begin
      bring_up();
      chk("R2 armed before disable", pgood, 1'b1);
      case (s)
        0: por = 1;
        1: en_pin = 0;
        2: en_logic = 0;
        default: vid = '1;
      endcase
      step();
      chk("R4 disable drops pgood", pgood, 1'b0);
      chk("R10 pd on disable", pg_pd, 1'b1);
      por = 0; en_pin = 1; en_logic = 1; vid = 6'd20;
      step(2);
      chk("R4 stays low until soft-start", pgood, 1'b0);
    end
  endtask

  task automatic t_uv_glitch();
    bring_up();
    uv = 1; step(); uv = 0;
    chk("R5 one-cycle uv ignored", pgood, 1'b1);
    step();
    chk("R5 still high after glitch", pgood, 1'b1);
    uv = 1; step(); uv = 0; step(); uv = 1; step(); uv = 0; step();
    chk("R5 alternating uv ignored", pgood, 1'b1);
  endtask

  task automatic t_uv_recover();
    bring_up();
    uv = 1; step();
    chk("R5 high after first uv sample", pgood, 1'b1);
    step();
    chk("R5 low after second uv sample", pgood, 1'b0);
    step(3);
    chk("R5 held low during uv", pgood, 1'b0);
    uv = 0; step();
    chk("R6 recovers after uv clears", pgood, 1'b1);
  endtask

  task automatic t_uv_then_disable();
    bring_up();
    uv = 1; step(2);
    chk("R5 low in uv", pgood, 1'b0);
    en_logic = 0; step(); en_logic = 1; step();
    uv = 0; step(2);
    chk("R6 no recovery after disable", pgood, 1'b0);
  endtask

  task automatic t_ov();
    bring_up();
    ov = 1; step();
    chk("R8 latch sets", ov_shdn, 1'b1);
    chk("R7 ov leaves pgood high", pgood, 1'b1);
    step(3);
    chk("R7 sustained ov leaves pgood high", pgood, 1'b1);
    ov = 0; step();
    chk("R8 latch holds", ov_shdn, 1'b1);
    vid = '1; step(); vid = 6'd20; step();
    chk("R9 no-cpu code keeps latch", ov_shdn, 1'b1);
    en_logic = 0; step(); en_logic = 1; step();
    chk("R9 logic enable keeps latch", ov_shdn, 1'b1);
    por = 1; step(); por = 0;
    chk("R9 por clears latch", ov_shdn, 1'b0);
    ov = 1; step(); ov = 0;
    chk("R8 latch sets again", ov_shdn, 1'b1);
    en_pin = 0; step(); en_pin = 1;
    chk("R9 pin low clears latch", ov_shdn, 1'b0);
    step();
    chk("R9 stays clear", ov_shdn, 1'b0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    step(2);
    t_reset();
    t_softstart();
    t_disables();
    t_uv_glitch();
    t_uv_recover();
    t_uv_then_disable();
    t_ov();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule